// File: doc/BRIEF.md
# Load Result Formatter

This block turns a raw 64-bit little-endian memory read word into the value that a load writes back to the register file. It takes four inputs: the read word, the low three bits of the access address, a load operation code, and the current contents of the 64-bit destination register. One clock later it presents the formatted writeback value together with a valid strobe.

It handles three groups of loads:

- **Plain loads** of 1, 2, 4 or 8 bytes. Byte and halfword loads come in zero-extending and sign-extending forms.
- **Unpack loads.** These read two or four bytes and widen each byte into its own 16-bit lane, with either zero or sign extension.
- **Shift-in loads.** These move the old destination register down by one byte or one halfword and insert the loaded item at the top, so the register behaves like a FIFO.

Two kinds of request produce no writeback. A misaligned request raises a misalignment flag, and an unknown operation code raises an illegal-operation flag.

The block sits after the data memory read, in the writeback path of a load pipeline. Address generation, the memory itself and the register file ports belong to the surrounding pipeline.

Top module: `ldfmt_unit`

## Requirements
- R1: Operation code 0 loads an unsigned byte and code 1 loads a signed byte. The byte is zero- or sign-extended to 32 bits in out_data[31:0].
- R2: Operation code 2 loads an unsigned halfword and code 3 loads a signed halfword. The halfword is zero- or sign-extended to 32 bits in out_data[31:0].
- R3: Operation code 4 returns a 32-bit word and code 5 returns the full 64-bit doubleword, both without extension. A 64-bit result (codes 5, 7, 9, 10, 11) sets out_pair. Any other result drives out_data[63:32] to zero with out_pair low.
- R4: Operation code 6 zero-extends byte i into halfword i for i = 0 and 1, giving a 32-bit result. Operation code 7 does the same for i = 0 to 3, giving a 64-bit result.
- R5: Operation codes 8 (two bytes) and 9 (four bytes) use the lane mapping of R4, but sign-extend each byte to 16 bits.
- R6: Operation code 10 returns the old destination value shifted right by 16 bits, with the loaded halfword placed in bits 63:48.
- R7: Operation code 11 returns the old destination value shifted right by 8 bits, with the loaded byte placed in bits 63:56.
- R8: The first loaded byte is the read-word byte at offset addr_lo. Bytes that follow come from higher offsets.
- R9: Access sizes are 1 byte (codes 0, 1, 11), 2 bytes (codes 2, 3, 6, 8, 10), 4 bytes (codes 4, 7, 9) and 8 bytes (code 5). If addr_lo is not a multiple of the access size, the next cycle has out_misalign high, out_valid low and out_data zero.
- R10: Operation codes 12 to 15 give, for exactly one cycle, out_illegal high, out_valid low and out_data zero.
- R11: Outputs follow an accepted request by exactly one clock. Without a request, out_valid, out_misalign and out_illegal are all low, and at most one of them is high in any cycle.
- R12: A synchronous reset clears out_valid, out_data, out_pair and both flags. This includes a request that is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Load operation code |
| addr_lo | input | 3 | Byte offset of the access within the read word |
| rd_data | input | 64 | Memory read word, little-endian |
| dst_old | input | 64 | Current destination register value |
| out_valid | output | 1 | Writeback value is valid |
| out_data | output | 64 | Writeback value |
| out_pair | output | 1 | Writeback covers the full 64 bits |
| out_misalign | output | 1 | Request was misaligned |
| out_illegal | output | 1 | Operation code was unknown |

## Verification
Every result and every flag is due at the first rising edge after the request is driven, because the only register is the output stage. The bench drives each request on a falling edge and samples all outputs on the next falling edge. Those samples therefore land exactly one register stage after the stimulus, and half a clock away from any edge.

For back-to-back requests, each result is checked in the same falling-edge slot that drives the following request. One further idle cycle confirms that the error flags have dropped again.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    localparam int unsigned WORD_W  = 64;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NBYTES  = WORD_W / BYTE_W;
    localparam int unsigned OFF_W   = $clog2(NBYTES);
    localparam int unsigned OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LD_UB  = 4'd0,
        OP_LD_SB  = 4'd1,
        OP_LD_UH  = 4'd2,
        OP_LD_SH  = 4'd3,
        OP_LD_W   = 4'd4,
        OP_LD_D   = 4'd5,
        OP_UNP_Z2 = 4'd6,
        OP_UNP_Z4 = 4'd7,
        OP_UNP_S2 = 4'd8,
        OP_UNP_S4 = 4'd9,
        OP_SHIN_H = 4'd10,
        OP_SHIN_B = 4'd11
    } ld_op_e;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_UNPACK = 2'd1,
        K_SHIFT  = 2'd2
    } ld_kind_e;

    typedef struct packed {
        logic     legal;
        ld_kind_e kind;
        logic     sgn;
        logic     pair;
        logic [1:0] size;
    } ld_ctl_t;

endpackage

// File: rtl/ldfmt_decode.sv
module ldfmt_decode
    import ldfmt_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ld_ctl_t         ctl
);

    always_comb begin
        ctl = '{legal: 1'b1, kind: K_PLAIN, sgn: 1'b0, pair: 1'b0, size: 2'd0};
        case (op)
            OP_LD_UB:  ctl.size = 2'd0;
            OP_LD_SB:  begin ctl.size = 2'd0; ctl.sgn = 1'b1; end
            OP_LD_UH:  ctl.size = 2'd1;
            OP_LD_SH:  begin ctl.size = 2'd1; ctl.sgn = 1'b1; end
            OP_LD_W:   ctl.size = 2'd2;
            OP_LD_D:   begin ctl.size = 2'd3; ctl.pair = 1'b1; end
            OP_UNP_Z2: begin ctl.size = 2'd1; ctl.kind = K_UNPACK; end
            OP_UNP_Z4: begin ctl.size = 2'd2; ctl.kind = K_UNPACK; ctl.pair = 1'b1; end
            OP_UNP_S2: begin ctl.size = 2'd1; ctl.kind = K_UNPACK; ctl.sgn = 1'b1; end
            OP_UNP_S4: begin
                ctl.size = 2'd2; ctl.kind = K_UNPACK; ctl.sgn = 1'b1; ctl.pair = 1'b1;
            end
            OP_SHIN_H: begin ctl.size = 2'd1; ctl.kind = K_SHIFT; ctl.pair = 1'b1; end
            OP_SHIN_B: begin ctl.size = 2'd0; ctl.kind = K_SHIFT; ctl.pair = 1'b1; end
            default:   ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldfmt_extract.sv
module ldfmt_extract
    import ldfmt_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [DW-1:0]    rd_data,
    input  logic [OFF_W-1:0] addr_lo,
    input  logic [1:0]       size,
    output logic [DW-1:0]    sel,
    output logic             misalign
);

    localparam int unsigned SH_W = OFF_W + 3;

    logic [OFF_W-1:0] size_mask;
    logic [SH_W-1:0]  bit_shift;

    always_comb begin
        size_mask = OFF_W'((1 << size) - 1);
        misalign  = |(addr_lo & size_mask);
        bit_shift = {addr_lo, 3'b000};
        sel       = rd_data >> bit_shift;
    end

endmodule

// File: rtl/ldfmt_compose.sv
module ldfmt_compose
    import ldfmt_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic [DW-1:0] sel,
    input  logic [DW-1:0] dst_old,
    input  ld_ctl_t       ctl,
    output logic [DW-1:0] result
);

    localparam int unsigned HALF_W = DW / 2;
    localparam int unsigned LANES  = NBYTES / 2;
    localparam int unsigned LANE_W = 2 * BYTE_W;

    logic [LANES*LANE_W-1:0] lanes;
    logic [DW-1:0]           plain_v;
    logic [DW-1:0]           unpack_v;
    logic [DW-1:0]           shift_v;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic top_bit;
        assign top_bit = ctl.sgn & sel[i*BYTE_W + BYTE_W - 1];
        assign lanes[i*LANE_W +: LANE_W] = {{BYTE_W{top_bit}}, sel[i*BYTE_W +: BYTE_W]};
    end

    always_comb begin
        plain_v = '0;
        case (ctl.size)
            2'd0: plain_v[HALF_W-1:0] =
                      {{(HALF_W-BYTE_W){ctl.sgn & sel[BYTE_W-1]}}, sel[BYTE_W-1:0]};
            2'd1: plain_v[HALF_W-1:0] =
                      {{(HALF_W-LANE_W){ctl.sgn & sel[LANE_W-1]}}, sel[LANE_W-1:0]};
            2'd2: plain_v[HALF_W-1:0] = sel[HALF_W-1:0];
            default: plain_v = sel;
        endcase

        unpack_v = '0;
        if (ctl.size == 2'd1) begin
            unpack_v[HALF_W-1:0] = lanes[HALF_W-1:0];
        end else begin
            unpack_v = lanes;
        end

        if (ctl.size == 2'd0) begin
            shift_v = (dst_old >> BYTE_W) |
                      (DW'(sel[BYTE_W-1:0]) << (DW - BYTE_W));
        end else begin
            shift_v = (dst_old >> LANE_W) |
                      (DW'(sel[LANE_W-1:0]) << (DW - LANE_W));
        end

        case (ctl.kind)
            K_UNPACK: result = unpack_v;
            K_SHIFT:  result = shift_v;
            default:  result = plain_v;
        endcase
    end

endmodule

// File: rtl/ldfmt_unit.sv
module ldfmt_unit
    import ldfmt_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [OFF_W-1:0] addr_lo,
    input  logic [DW-1:0]    rd_data,
    input  logic [DW-1:0]    dst_old,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic             out_pair,
    output logic             out_misalign,
    output logic             out_illegal
);

    typedef struct packed {
        logic          valid;
        logic          pair;
        logic          misalign;
        logic          illegal;
        logic [DW-1:0] data;
    } wb_t;

    ld_ctl_t       ctl;
    logic [DW-1:0] sel;
    logic          misalign;
    logic [DW-1:0] result;
    wb_t           wb_d;
    wb_t           wb_q;

    ldfmt_decode u_decode (
        .op  (op),
        .ctl (ctl)
    );

    ldfmt_extract #(.DW(DW)) u_extract (
        .rd_data  (rd_data),
        .addr_lo  (addr_lo),
        .size     (ctl.size),
        .sel      (sel),
        .misalign (misalign)
    );

    ldfmt_compose #(.DW(DW)) u_compose (
        .sel     (sel),
        .dst_old (dst_old),
        .ctl     (ctl),
        .result  (result)
    );

    always_comb begin
        wb_d = '0;
        if (in_valid) begin
            if (!ctl.legal) begin
                wb_d.illegal = 1'b1;
            end else if (misalign) begin
                wb_d.misalign = 1'b1;
            end else begin
                wb_d.valid = 1'b1;
                wb_d.pair  = ctl.pair;
                wb_d.data  = result;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign out_valid    = wb_q.valid;
    assign out_data     = wb_q.data;
    assign out_pair     = wb_q.pair;
    assign out_misalign = wb_q.misalign;
    assign out_illegal  = wb_q.illegal;

endmodule

// File: rtl/ldfmt_unit_chk.sv
module ldfmt_unit_chk
    import ldfmt_pkg::*;
#(
    parameter int unsigned DW = WORD_W
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [OP_W-1:0] op,
    input logic [DW-1:0]   dst_old,
    input logic            out_valid,
    input logic [DW-1:0]   out_data,
    input logic            out_pair,
    input logic            out_misalign,
    input logic            out_illegal
);

    localparam int unsigned HALF_W = DW / 2;

    assert_one_flag_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_valid, out_misalign, out_illegal}));

    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_misalign && !out_illegal);

    assert_upper_clear_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_pair |-> out_data[DW-1:HALF_W] == '0);

    assert_illegal_op_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid && op >= 4'd12 |=> out_illegal && !out_valid && out_data == '0);

    assert_misalign_zero_R9: assert property (@(posedge clk) disable iff (rst)
        out_misalign |-> out_data == '0 && !out_pair);

    assert_shift_half_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == OP_SHIN_H |=>
            !out_valid || out_data[DW-17:0] == $past(dst_old[DW-1:16]));

    assert_reset_clear_R12: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !out_misalign && !out_illegal && out_data == '0);

endmodule

bind ldfmt_unit ldfmt_unit_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .op           (op),
    .dst_old      (dst_old),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_pair     (out_pair),
    .out_misalign (out_misalign),
    .out_illegal  (out_illegal)
);

// File: tb/ldfmt_unit_tb.sv
`timescale 1ns/1ps
module ldfmt_unit_tb;

    localparam time PERIOD = 20ns;
    localparam logic [63:0] RD  = 64'hE877_9655_C433_82F1;
    localparam logic [63:0] DST = 64'h1122_3344_5566_7788;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [2:0]  addr_lo = '0;
    logic [63:0] rd_data = '0;
    logic [63:0] dst_old = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_pair;
    logic        out_misalign;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    ldfmt_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .op           (op),
        .addr_lo      (addr_lo),
        .rd_data      (rd_data),
        .dst_old      (dst_old),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_pair     (out_pair),
        .out_misalign (out_misalign),
        .out_illegal  (out_illegal)
    );

    task automatic check(string req, logic [67:0] act, logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [67:0] pack_out();
        return {out_valid, out_pair, out_misalign, out_illegal, out_data};
    endfunction

    task automatic drive(logic [3:0] o, logic [2:0] a, logic [63:0] rd, logic [63:0] dst);
        in_valid = 1'b1; op = o; addr_lo = a; rd_data = rd; dst_old = dst;
    endtask

    // one request; result checked one clock later at the falling edge
    task automatic one(string req, logic [3:0] o, logic [2:0] a,
                       logic [3:0] flags, logic [63:0] exp);
        @(negedge clk);
        drive(o, a, RD, DST);
        @(negedge clk);
        in_valid = 1'b0;
        check(req, pack_out(), {flags, exp});
    endtask

    localparam logic [3:0] F_OK  = 4'b1000;
    localparam logic [3:0] F_PR  = 4'b1100;
    localparam logic [3:0] F_MIS = 4'b0010;
    localparam logic [3:0] F_ILL = 4'b0001;

    task automatic t_reset();
        check("R12 reset state", pack_out(), '0);
    endtask

    task automatic t_bytes();
        one("R1 unsigned byte", 4'd0, 3'd0, F_OK, 64'h0000_0000_0000_00F1);
        one("R1 signed byte neg", 4'd1, 3'd0, F_OK, 64'h0000_0000_FFFF_FFF1);
        one("R1 R8 signed byte pos off2", 4'd1, 3'd2, F_OK, 64'h0000_0000_0000_0033);
        one("R8 unsigned byte off7", 4'd0, 3'd7, F_OK, 64'h0000_0000_0000_00E8);
    endtask

    task automatic t_halves();
        one("R2 unsigned half", 4'd2, 3'd0, F_OK, 64'h0000_0000_0000_82F1);
        one("R2 signed half", 4'd3, 3'd0, F_OK, 64'h0000_0000_FFFF_82F1);
        one("R2 R8 signed half off4", 4'd3, 3'd4, F_OK, 64'h0000_0000_FFFF_9655);
        one("R2 R8 unsigned half off6", 4'd2, 3'd6, F_OK, 64'h0000_0000_0000_E877);
    endtask

    task automatic t_words();
        one("R3 word off0", 4'd4, 3'd0, F_OK, 64'h0000_0000_C433_82F1);
        one("R3 R8 word off4", 4'd4, 3'd4, F_OK, 64'h0000_0000_E877_9655);
        one("R3 doubleword pair", 4'd5, 3'd0, F_PR, RD);
    endtask

    task automatic t_unpack();
        one("R4 zero unpack 2", 4'd6, 3'd0, F_OK, 64'h0000_0000_0082_00F1);
        one("R4 R8 zero unpack 4 off4", 4'd7, 3'd4, F_PR, 64'h00E8_0077_0096_0055);
        one("R5 sign unpack 2", 4'd8, 3'd0, F_OK, 64'h0000_0000_FF82_FFF1);
        one("R5 sign unpack 4", 4'd9, 3'd0, F_PR, 64'hFFC4_0033_FF82_FFF1);
    endtask

    task automatic t_shift();
        one("R6 shift-in half off2", 4'd10, 3'd2, F_PR, 64'hC433_1122_3344_5566);
        one("R7 shift-in byte off5", 4'd11, 3'd5, F_PR, 64'h9611_2233_4455_6677);
    endtask

    task automatic t_misalign();
        one("R9 half off1", 4'd2, 3'd1, F_MIS, '0);
        one("R9 word off2", 4'd4, 3'd2, F_MIS, '0);
        one("R9 double off4", 4'd5, 3'd4, F_MIS, '0);
        one("R9 unpack4 off2", 4'd7, 3'd2, F_MIS, '0);
        one("R9 shift-in half off3", 4'd10, 3'd3, F_MIS, '0);
    endtask

    task automatic t_illegal();
        one("R10 illegal op 13", 4'd13, 3'd0, F_ILL, '0);
        @(negedge clk);
        check("R10 R11 flag drops after one cycle", pack_out(), '0);
        one("R10 illegal op 15", 4'd15, 3'd0, F_ILL, '0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(4'd1, 3'd0, RD, DST);
        @(negedge clk);
        check("R11 first of pair", pack_out(), {F_OK, 64'h0000_0000_FFFF_FFF1});
        drive(4'd11, 3'd0, RD, 64'hAABB_CCDD_EEFF_0011);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 R7 second of pair", pack_out(), {F_PR, 64'hF1AA_BBCC_DDEE_FF00});
        @(negedge clk);
        check("R11 idle after pair", pack_out(), '0);
    endtask

    task automatic t_reset_inflight();
        @(negedge clk);
        drive(4'd5, 3'd0, RD, DST);
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        check("R12 reset drops in-flight", pack_out(), '0);
    endtask

    initial begin : watchdog
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bytes();
        t_halves();
        t_words();
        t_unpack();
        t_shift();
        t_misalign();
        t_illegal();
        t_back_to_back();
        t_reset_inflight();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule